// File: doc/BRIEF.md
# GPIO interrupt aggregation unit

This block collects interrupt requests from 32 general-purpose input lines and reduces them to four group requests for a main interrupt controller. Each pin is synchronized by two flops and then XORed with a per-line polarity bit. The result is the line's sampled input value, and software can read it back. A line can raise an interrupt in two ways:

- **Level path.** The sampled value is used as it is and is enabled by a level mask.
- **Edge path.** A rising transition of the sampled value sets a sticky cause bit, which is enabled by an edge mask.

Software picks high or rising triggering with polarity 0, and low or falling triggering with polarity 1. Only lines that the direction register marks as inputs take part.

The per-line requests of each block of eight neighbouring lines are ORed into one registered output. That output stays high for as long as any enabled source in the group is active. Software reaches all state through a single-cycle register port with word addresses. Read data is combinational.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset the polarity, direction, level mask, edge mask and edge cause registers all read 0, and all four group outputs are 0.
- R2: Address 0 reads the sampled input. Each bit equals the pin value when that line's polarity bit (address 1) is 0, and the inverted pin value when it is 1. The pin passes through two synchronizing flops first. Writes to address 0 are ignored.
- R3: A line with its level mask bit (address 3) set raises its group output while its sampled input is 1. The output falls again once the sampled input returns to 0.
- R4: A 0-to-1 transition of a line's sampled input sets its bit in the edge cause register (address 5). The bit stays set after the input returns to 0. With the edge mask bit (address 4) set, the group output is 1 while the cause bit is set.
- R5: Writing the edge cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: With polarity 1, a falling pin sets the edge cause bit and a rising pin does not.
- R7: A line whose direction bit (address 2, 1 = input) is 0 contributes to no group output. Its edge cause bit still latches.
- R8: Group output bit g is the OR of the enabled requests of lines 8g to 8g+7, and of no other lines.
- R9: When a new edge and a write clearing the same cause bit occur in the same cycle, the bit ends up set.
- R10: The group outputs are registered. A change in an enabled request reaches the output one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous GPIO pin levels |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| grp_irq_o | output | 4 | Registered group interrupt requests, one per eight lines |

## Verification
The patterns are chosen so that each one separates two possible behaviours:

- **Level versus edge.** A level-masked pin is raised and then lowered, so the output must follow the pin. An edge-masked pin goes through the same sequence, so the output must hold after the pin drops.
- **Polarity.** The same pin pattern is read with polarity 0 and then with polarity 1. A falling edge on an inverted line must set its cause bit, while a rising edge on that line must not.
- **Group boundaries.** Single high pins at lines 31 and 16, and a pair at lines 0 and 8, separate the four groups.
- **Direction gating.** A line marked as output is driven with its edge mask set, which separates the direction gate from the masks.
- **Edge against clear.** A clear write is placed exactly in the cycle in which a new edge is detected, which separates the two orderings.

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  parameter int AW    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LINES-1:0]                pins_i,
  input  logic [AW-1:0]                   reg_addr_i,
  input  logic                            reg_wr_i,
  input  logic [LINES-1:0]                reg_wdata_i,
  output logic [LINES-1:0]                reg_rdata_o,
  output logic [(LINES+GROUP-1)/GROUP-1:0] grp_irq_o
);
  localparam int GROUPS = (LINES + GROUP - 1) / GROUP;
  localparam int PADDED = GROUPS * GROUP;
  localparam logic [AW-1:0] A_DIN   = AW'(0);
  localparam logic [AW-1:0] A_POL   = AW'(1);
  localparam logic [AW-1:0] A_DIR   = AW'(2);
  localparam logic [AW-1:0] A_LMASK = AW'(3);
  localparam logic [AW-1:0] A_EMASK = AW'(4);
  localparam logic [AW-1:0] A_CAUSE = AW'(5);

  logic [LINES-1:0] sync1, sync2, adj_prev;
  logic [LINES-1:0] pol, dir_in, lmask, emask, cause;
  logic [LINES-1:0] din, edge_hit, line_irq;
  logic [PADDED-1:0] line_pad;
  logic [GROUPS-1:0] grp_q;

  assign din      = sync2 ^ pol;
  assign edge_hit = din & ~adj_prev;
  assign line_irq = dir_in & ((din & lmask) | (cause & emask));
  assign line_pad = PADDED'(line_irq);
  assign grp_irq_o = grp_q;

  logic wr_pol, wr_dir, wr_lm, wr_em, wr_cause;
  assign wr_pol   = reg_wr_i && reg_addr_i == A_POL;
  assign wr_dir   = reg_wr_i && reg_addr_i == A_DIR;
  assign wr_lm    = reg_wr_i && reg_addr_i == A_LMASK;
  assign wr_em    = reg_wr_i && reg_addr_i == A_EMASK;
  assign wr_cause = reg_wr_i && reg_addr_i == A_CAUSE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      adj_prev <= '0;
    end else begin
      sync1    <= pins_i;
      sync2    <= sync1;
      adj_prev <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol    <= '0;
      dir_in <= '0;
      lmask  <= '0;
      emask  <= '0;
    end else begin
      if (wr_pol) pol    <= reg_wdata_i;
      if (wr_dir) dir_in <= reg_wdata_i;
      if (wr_lm)  lmask  <= reg_wdata_i;
      if (wr_em)  emask  <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (wr_cause ? (cause & reg_wdata_i) : cause) | edge_hit;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[g] <= 1'b0;
      else        grp_q[g] <= |line_pad[g*GROUP +: GROUP];
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_DIN:   reg_rdata_o = din;
      A_POL:   reg_rdata_o = pol;
      A_DIR:   reg_rdata_o = dir_in;
      A_LMASK: reg_rdata_o = lmask;
      A_EMASK: reg_rdata_o = emask;
      A_CAUSE: reg_rdata_o = cause;
      default: reg_rdata_o = '0;
    endcase
  end

  p_quiet_no_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lmask == '0 && emask == '0) |=> grp_irq_o == '0);

  p_cause_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> (cause & $past(cause)) == $past(cause));

  p_no_input_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in == '0 |=> grp_irq_o == '0);

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit != '0 |=> (cause & $past(edge_hit)) == $past(edge_hit));

  p_grp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq == '0 |=> grp_irq_o == '0);
endmodule

// File: tb/gpio_irq_agg_tb.sv
module gpio_irq_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pins = '0;
  logic [2:0]  addr = '0;
  logic        wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;

  gpio_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .grp_irq_o(grp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_grp;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_grp ? {28'b0, grp} : rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    settle();
    addr = a;
    it.is_grp = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_grp(input logic [3:0] e, input string tag);
    item_t it;
    settle();
    it.is_grp = 1; it.exp = {28'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 1; a < 6; a++) chk_reg(3'(a), 32'h0, "R1 reset register");
    chk_grp(4'h0, "R1 reset group outputs");

    wr_reg(3'd2, 32'hFFFF_FFFF);
    pins = 32'hA5C3_0F00;
    chk_reg(3'd0, 32'hA5C3_0F00, "R2 data-in polarity 0");
    wr_reg(3'd1, 32'hFFFF_0000);
    chk_reg(3'd0, 32'h5A3C_0F00, "R2 data-in polarity mixed");
    wr_reg(3'd0, 32'h1234_5678);
    chk_reg(3'd0, 32'h5A3C_0F00, "R2 write to data-in ignored");
    wr_reg(3'd1, 32'h0);
    pins = '0;
    settle();
    wr_reg(3'd5, 32'h0);
    chk_reg(3'd5, 32'h0, "R5 cause cleared");

    wr_reg(3'd3, 32'h8);
    pins = 32'h8;
    chk_grp(4'h1, "R3 level high raises group 0");
    pins = 32'h0;
    chk_grp(4'h0, "R3 level low drops group 0");

    wr_reg(3'd3, 32'hFFFF_FFFF);
    pins = 32'h8000_0000;
    chk_grp(4'h8, "R8 line 31 maps to group 3");
    pins = 32'h0001_0000;
    chk_grp(4'h4, "R8 line 16 maps to group 2");
    pins = 32'h0000_0101;
    chk_grp(4'h3, "R8 lines 0 and 8 map to groups 0 and 1");
    pins = 32'h0;
    wr_reg(3'd3, 32'h0);
    settle();
    wr_reg(3'd5, 32'h0);

    wr_reg(3'd4, 32'h200);
    pins = 32'h200;
    chk_reg(3'd5, 32'h200, "R4 rising edge sets cause");
    chk_grp(4'h2, "R4 edge raises group 1");
    pins = 32'h0;
    chk_reg(3'd5, 32'h200, "R4 cause sticky after pin drop");
    chk_grp(4'h2, "R4 group holds after pin drop");

    wr_reg(3'd5, 32'hFFFF_FFFF);
    chk_reg(3'd5, 32'h200, "R5 write one keeps cause");
    wr_reg(3'd5, 32'hFFFF_FDFF);
    chk_reg(3'd5, 32'h0, "R5 write zero clears cause");
    chk_grp(4'h0, "R5 group drops after clear");

    pins = 32'h0010_0000;
    settle();
    wr_reg(3'd1, 32'h0010_0000);
    wr_reg(3'd5, 32'h0);
    chk_reg(3'd5, 32'h0, "R6 no cause with inverted high pin");
    pins = 32'h0;
    chk_reg(3'd5, 32'h0010_0000, "R6 falling pin sets cause");
    wr_reg(3'd5, 32'h0);
    pins = 32'h0010_0000;
    chk_reg(3'd5, 32'h0, "R6 rising pin ignored with polarity 1");
    wr_reg(3'd1, 32'h0);
    pins = 32'h0;
    settle();
    wr_reg(3'd5, 32'h0);

    wr_reg(3'd2, ~32'h200);
    pins = 32'h200;
    chk_reg(3'd5, 32'h200, "R7 cause latches on output line");
    chk_grp(4'h0, "R7 output line gated");
    wr_reg(3'd2, 32'hFFFF_FFFF);
    chk_grp(4'h2, "R7 input line passes");
    pins = 32'h0;
    settle();

    @(negedge clk);
    pins = 32'h1000;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd5; wdata = 32'h0; wr = 1;
    @(negedge clk);
    wr = 0;
    chk_reg(3'd5, 32'h1000, "R9 edge wins over same-cycle clear");

    pins = 32'h0;
    settle();
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd3, 32'h4);
    @(negedge clk);
    pins = 32'h4;
    @(negedge clk);
    @(negedge clk);
    begin
      item_t it;
      it.is_grp = 1; it.exp = 32'h0; it.tag = "R10 group not yet set in edge cycle";
      exp_q.push_back(it);
    end
    @(negedge clk);
    begin
      item_t it;
      it.is_grp = 1; it.exp = 32'h1; it.tag = "R10 group set one clock later";
      exp_q.push_back(it);
    end
    @(negedge clk);

    settle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule